// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block sits between eight interrupt request lines and a processor's interrupt input. It keeps three 8-bit registers: pending requests, levels in service, and a mask. From these it chooses the most urgent level that is allowed to interrupt and drives a single interrupt output. When the processor acknowledges, the chosen level moves from the pending register into the in-service register. The level's number is presented on `vec_level` so that separate vector logic can form the handler address.

Priority is a ring of eight levels. It is defined by a "bottom" pointer: the level one above the bottom has the highest priority, and priority falls going upward around the ring. Software adjusts the ring and the in-service state through decoded one-cycle commands: general and level-specific end-of-service, rotating forms of both, setting the bottom level explicitly, and turning selective masking on and off. Static configuration inputs select edge or level request capture and automatic end-of-service. In automatic mode the ring can optionally rotate at each completion.

Top module: `prio_irq_resolver`

## Requirements
- R1: After reset `req_reg`, `isr_reg` and `mask_reg` are 0, `irq_out` is 0 and `vec_level` is 7. The bottom pointer is 7, so level 0 is the most urgent and level 7 the least.
- R2: With `cfg_level_trig`=0, a 0-to-1 change on a line sets its `req_reg` bit at the next clock edge. A line that stays high raises no further request after its request has been taken.
- R3: With `cfg_level_trig`=1, `req_reg` follows the lines one clock later and nothing is latched. A line still high after its request is taken requests again on the following cycle.
- R4: An `ack` pulse while `irq_out`=1 sets the `isr_reg` bit of the winning level. At the same edge it clears that level's `req_reg` bit and loads the level into `vec_level`.
- R5: With selective masking off, a set `isr_reg` bit blocks requests at its own and less urgent levels. A more urgent unmasked request still raises `irq_out`.
- R6: `cmd_op`=1 (general end-of-service) clears the most urgent set `isr_reg` bit. `cmd_op`=2 (specific end-of-service) clears the bit numbered by `cmd_level`. Both take effect at the edge where `cmd_valid`=1.
- R7: `cmd_op`=3 acts like `cmd_op`=1 and also makes the cleared level the bottom, so the level above it becomes the most urgent.
- R8: `cmd_op`=5 sets the bottom to `cmd_level`. `cmd_op`=4 clears `isr_reg` bit `cmd_level` and also sets the bottom to `cmd_level`.
- R9: `mask_we` loads `mask_data` into `mask_reg`, where bit n masks level n. A masked request stays in `req_reg` but never raises `irq_out`.
- R10: `cmd_op`=6 turns selective masking on and `cmd_op`=7 turns it off. While it is on, every unmasked pending level that is not itself in service is eligible, regardless of urgency. A general end-of-service also skips any in-service bit whose mask bit is set.
- R11: An `ack` pulse while `irq_out`=0 loads 7 into `vec_level` and leaves `isr_reg` and `req_reg` unchanged.
- R12: With `cfg_auto_eoi`=1, an `ack_last` pulse performs a general end-of-service. If `cfg_auto_rotate` is also 1, the level cleared by that pulse becomes the bottom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 8 | Request lines, bit n is level n |
| cfg_level_trig | input | 1 | 1: level capture, 0: edge capture |
| cfg_auto_eoi | input | 1 | Automatic end-of-service on `ack_last` |
| cfg_auto_rotate | input | 1 | Rotate the ring on automatic end-of-service |
| ack | input | 1 | Acknowledge pulse that takes the winning level |
| ack_last | input | 1 | Pulse marking the end of the acknowledge sequence |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R6 to R10) |
| cmd_level | input | 3 | Level operand of a command |
| mask_we | input | 1 | Mask register write strobe |
| mask_data | input | 8 | New mask value |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_level | output | 3 | Level taken by the last acknowledge |
| req_reg | output | 8 | Pending request register |
| isr_reg | output | 8 | In-service register |
| mask_reg | output | 8 | Mask register |

## Verification
The bench checks that less urgent requests stay blocked behind a level in service, while a more urgent one still gets through. A resolver that compares levels by their raw numbers instead of their ring position would either take the wrong level after a rotation or leave the output asserted. The bench also covers two masking cases. An empty acknowledge must report level 7 without disturbing the registers. Under selective masking, a general end-of-service must skip a masked in-service bit; a design that ignored the mask there would drop service from the wrong level. Level-mode re-requests and edge-mode held lines are checked as well, because a capture stage that mixes the two styles either loses requests or keeps re-requesting.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP         = 3'd0,
    CMD_EOI_ANY     = 3'd1,
    CMD_EOI_LVL     = 3'd2,
    CMD_EOI_ANY_ROT = 3'd3,
    CMD_EOI_LVL_ROT = 3'd4,
    CMD_SET_BOTTOM  = 3'd5,
    CMD_SMM_ON      = 3'd6,
    CMD_SMM_OFF     = 3'd7
  } pir_cmd_e;
endpackage

// File: rtl/pir_prio_pick.sv
// Finds the most urgent set bit of vec on a ring whose least urgent
// position is 'bottom'. N must be a power of two so the ring wraps for free.
module pir_prio_pick #(
  parameter int N_LEVELS = 8,
  localparam int LVL_W = $clog2(N_LEVELS)
) (
  input  logic [N_LEVELS-1:0] vec,
  input  logic [LVL_W-1:0]    bottom,
  output logic                found,
  output logic [LVL_W-1:0]    idx
);
  logic [LVL_W-1:0] lvl;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    lvl   = '0;
    // walk from least urgent to most urgent; the last hit wins
    for (int k = N_LEVELS - 1; k >= 0; k--) begin
      lvl = bottom + LVL_W'(1) + LVL_W'(k);
      if (vec[lvl]) begin
        found = 1'b1;
        idx   = lvl;
      end
    end
  end
endmodule

// File: rtl/pir_req_capture.sv
// Edge or level capture of request lines into the pending register.
module pir_req_capture #(
  parameter int N_LEVELS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LEVELS-1:0] lines,
  input  logic                level_mode,
  input  logic [N_LEVELS-1:0] take_vec,
  output logic [N_LEVELS-1:0] req_q
);
  logic [N_LEVELS-1:0] prev_q;
  logic [N_LEVELS-1:0] prev_d;
  logic [N_LEVELS-1:0] req_d;
  logic [N_LEVELS-1:0] rise;

  always_comb begin
    rise   = lines & ~prev_q;
    prev_d = lines;
    if (level_mode) begin
      req_d = lines & ~take_vec;
    end else begin
      req_d = (req_q & ~take_vec) | rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= prev_d;
      req_q  <= req_d;
    end
  end
endmodule

// File: rtl/pir_eligibility.sv
// Decides which pending levels may raise the interrupt.
module pir_eligibility #(
  parameter int N_LEVELS = 8,
  localparam int LVL_W = $clog2(N_LEVELS)
) (
  input  logic [N_LEVELS-1:0] req,
  input  logic [N_LEVELS-1:0] mask,
  input  logic [N_LEVELS-1:0] isr,
  input  logic [LVL_W-1:0]    bottom,
  input  logic                smm,
  output logic [N_LEVELS-1:0] elig
);
  logic             isr_found;
  logic [LVL_W-1:0] isr_top;
  logic [LVL_W-1:0] top_rank;
  logic [N_LEVELS-1:0] allowed;

  pir_prio_pick #(.N_LEVELS(N_LEVELS)) u_isr_top (
    .vec    (isr),
    .bottom (bottom),
    .found  (isr_found),
    .idx    (isr_top)
  );

  // rank 0 is the most urgent position on the ring
  assign top_rank = isr_top - bottom - LVL_W'(1);

  for (genvar g = 0; g < N_LEVELS; g++) begin : g_lvl
    logic [LVL_W-1:0] rank_g;
    assign rank_g     = LVL_W'(g) - bottom - LVL_W'(1);
    assign allowed[g] = smm ? !isr[g] : (!isr_found || (rank_g < top_rank));
  end

  assign elig = req & ~mask & allowed;
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver
  import prio_irq_pkg::*;
#(
  parameter int N_LEVELS = 8,
  localparam int LVL_W = $clog2(N_LEVELS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LEVELS-1:0] irq_lines,
  input  logic                cfg_level_trig,
  input  logic                cfg_auto_eoi,
  input  logic                cfg_auto_rotate,
  input  logic                ack,
  input  logic                ack_last,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [LVL_W-1:0]    cmd_level,
  input  logic                mask_we,
  input  logic [N_LEVELS-1:0] mask_data,
  output logic                irq_out,
  output logic [LVL_W-1:0]    vec_level,
  output logic [N_LEVELS-1:0] req_reg,
  output logic [N_LEVELS-1:0] isr_reg,
  output logic [N_LEVELS-1:0] mask_reg
);
  localparam logic [N_LEVELS-1:0] ONE_HOT0 = N_LEVELS'(1);
  localparam logic [LVL_W-1:0]    LVL_LAST = LVL_W'(N_LEVELS - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // state
  logic [N_LEVELS-1:0] isr_q, isr_d;
  logic [N_LEVELS-1:0] mask_q, mask_d;
  logic [LVL_W-1:0]    bottom_q, bottom_d;
  logic [LVL_W-1:0]    vec_q, vec_d;
  logic                smm_q, smm_d;

  logic [N_LEVELS-1:0] req_q;
  logic [N_LEVELS-1:0] elig;
  logic                win_found;
  logic [LVL_W-1:0]    win_idx;
  logic                eoi_found;
  logic [LVL_W-1:0]    eoi_idx;
  logic [N_LEVELS-1:0] eoi_cand;
  logic [N_LEVELS-1:0] take_vec;
  logic [N_LEVELS-1:0] clr_vec;
  logic                take;
  logic                gen_eoi;
  logic                auto_eoi;
  pir_cmd_e            cmd;

  pir_req_capture #(.N_LEVELS(N_LEVELS)) u_capture (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lines      (irq_lines),
    .level_mode (cfg_level_trig),
    .take_vec   (take_vec),
    .req_q      (req_q)
  );

  pir_eligibility #(.N_LEVELS(N_LEVELS)) u_elig (
    .req    (req_q),
    .mask   (mask_q),
    .isr    (isr_q),
    .bottom (bottom_q),
    .smm    (smm_q),
    .elig   (elig)
  );

  pir_prio_pick #(.N_LEVELS(N_LEVELS)) u_win (
    .vec    (elig),
    .bottom (bottom_q),
    .found  (win_found),
    .idx    (win_idx)
  );

  // general end-of-service candidates: selective masking hides masked bits
  assign eoi_cand = smm_q ? (isr_q & ~mask_q) : isr_q;

  pir_prio_pick #(.N_LEVELS(N_LEVELS)) u_eoi (
    .vec    (eoi_cand),
    .bottom (bottom_q),
    .found  (eoi_found),
    .idx    (eoi_idx)
  );

  always_comb begin
    cmd      = pir_cmd_e'(cmd_op);
    take     = ack && win_found;
    take_vec = take ? (ONE_HOT0 << win_idx) : '0;
    gen_eoi  = cmd_valid && ((cmd == CMD_EOI_ANY) || (cmd == CMD_EOI_ANY_ROT));
    auto_eoi = ack_last && cfg_auto_eoi;

    clr_vec = '0;
    if ((gen_eoi || auto_eoi) && eoi_found) clr_vec = clr_vec | (ONE_HOT0 << eoi_idx);
    if (cmd_valid && ((cmd == CMD_EOI_LVL) || (cmd == CMD_EOI_LVL_ROT)))
      clr_vec = clr_vec | (ONE_HOT0 << cmd_level);

    isr_d = (isr_q & ~clr_vec) | take_vec;

    bottom_d = bottom_q;
    if (cmd_valid && ((cmd == CMD_SET_BOTTOM) || (cmd == CMD_EOI_LVL_ROT))) begin
      bottom_d = cmd_level;
    end else if (cmd_valid && (cmd == CMD_EOI_ANY_ROT) && eoi_found) begin
      bottom_d = eoi_idx;
    end else if (auto_eoi && cfg_auto_rotate && eoi_found) begin
      bottom_d = eoi_idx;
    end

    smm_d = smm_q;
    if (cmd_valid && (cmd == CMD_SMM_ON))  smm_d = 1'b1;
    if (cmd_valid && (cmd == CMD_SMM_OFF)) smm_d = 1'b0;

    mask_d = mask_we ? mask_data : mask_q;
    vec_d  = ack ? (win_found ? win_idx : LVL_LAST) : vec_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      isr_q    <= '0;
      mask_q   <= '0;
      bottom_q <= LVL_LAST;
      vec_q    <= LVL_LAST;
      smm_q    <= 1'b0;
    end else begin
      isr_q    <= isr_d;
      mask_q   <= mask_d;
      bottom_q <= bottom_d;
      vec_q    <= vec_d;
      smm_q    <= smm_d;
    end
  end

  assign irq_out   = |elig;
  assign vec_level = vec_q;
  assign req_reg   = req_q;
  assign isr_reg   = isr_q;
  assign mask_reg  = mask_q;
endmodule

// File: rtl/prio_irq_resolver_chk.sv
module prio_irq_resolver_chk #(
  parameter int N_LEVELS = 8,
  localparam int LVL_W = $clog2(N_LEVELS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ack,
  input logic                ack_last,
  input logic                cmd_valid,
  input logic                mask_we,
  input logic [N_LEVELS-1:0] mask_data,
  input logic                irq_out,
  input logic [LVL_W-1:0]    vec_level,
  input logic [N_LEVELS-1:0] req_reg,
  input logic [N_LEVELS-1:0] isr_reg,
  input logic [N_LEVELS-1:0] mask_reg
);
  assert_ack_sets_isr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out) |=> isr_reg[vec_level]);

  assert_empty_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_out && !cmd_valid && !ack_last) |=>
      (vec_level == LVL_W'(N_LEVELS - 1)) && $stable(isr_reg));

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_reg & ~mask_reg) == '0) |-> !irq_out);

  assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_reg == $past(mask_data)));

  assert_isr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !cmd_valid && !ack_last) |=> $stable(isr_reg));

  assert_irq_has_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((req_reg & ~isr_reg & ~mask_reg) != '0));
endmodule

bind prio_irq_resolver prio_irq_resolver_chk #(.N_LEVELS(N_LEVELS)) chk_i (.*);

// File: tb/prio_irq_resolver_tb_top.sv
module prio_irq_resolver_tb_top;
  logic       clk;
  logic       rst_n;
  logic [7:0] irq_lines;
  logic       cfg_level_trig, cfg_auto_eoi, cfg_auto_rotate;
  logic       ack, ack_last, cmd_valid, mask_we;
  logic [2:0] cmd_op, cmd_level;
  logic [7:0] mask_data;
  logic       irq_out;
  logic [2:0] vec_level;
  logic [7:0] req_reg, isr_reg, mask_reg;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    string      tag;
    logic [7:0] req;
    logic [7:0] isr;
    logic [7:0] mask;
    logic       irq;
    logic [2:0] vec;
  } exp_t;
  exp_t sb_q[$];

  prio_irq_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .cfg_level_trig(cfg_level_trig), .cfg_auto_eoi(cfg_auto_eoi),
    .cfg_auto_rotate(cfg_auto_rotate), .ack(ack), .ack_last(ack_last),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_level(cmd_level),
    .mask_we(mask_we), .mask_data(mask_data), .irq_out(irq_out),
    .vec_level(vec_level), .req_reg(req_reg), .isr_reg(isr_reg),
    .mask_reg(mask_reg)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // monitor: compare every queued expectation mid-cycle
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (req_reg !== e.req || isr_reg !== e.isr || mask_reg !== e.mask ||
          irq_out !== e.irq || vec_level !== e.vec) begin
        errors++;
        $display("FAIL %s: got req=%h isr=%h mask=%h irq=%b vec=%0d exp req=%h isr=%h mask=%h irq=%b vec=%0d",
                 e.tag, req_reg, isr_reg, mask_reg, irq_out, vec_level,
                 e.req, e.isr, e.mask, e.irq, e.vec);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    ack = 0; ack_last = 0; cmd_valid = 0; mask_we = 0;
  endtask

  task automatic expect_st(string tag, logic [7:0] r, logic [7:0] s,
                           logic [7:0] m, logic q, logic [2:0] v);
    exp_t e;
    e.tag = tag; e.req = r; e.isr = s; e.mask = m; e.irq = q; e.vec = v;
    sb_q.push_back(e);
  endtask

  task automatic lines(logic [7:0] v);
    irq_lines = v; tick();
  endtask

  task automatic do_ack();
    ack = 1; tick();
  endtask

  task automatic do_last();
    ack_last = 1; tick();
  endtask

  task automatic cmd(logic [2:0] op, logic [2:0] lvl);
    cmd_valid = 1; cmd_op = op; cmd_level = lvl; tick();
  endtask

  task automatic set_mask(logic [7:0] m);
    mask_we = 1; mask_data = m; tick();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq_lines = 0; cfg_level_trig = 0; cfg_auto_eoi = 0;
    cfg_auto_rotate = 0; ack = 0; ack_last = 0; cmd_valid = 0; cmd_op = 0;
    cmd_level = 0; mask_we = 0; mask_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) tick();
    expect_st("R1 reset", 8'h00, 8'h00, 8'h00, 0, 3'd7); tick();

    // R2 / R4 edge capture and acknowledge
    lines(8'h10); expect_st("R2 rise latches", 8'h10, 8'h00, 8'h00, 1, 3'd7);
    do_ack();     expect_st("R4 ack moves level 4", 8'h00, 8'h10, 8'h00, 0, 3'd4);
    tick();       expect_st("R2 held line no re-request", 8'h00, 8'h10, 8'h00, 0, 3'd4);
    cmd(3'd1, 3'd0); expect_st("R6 general eoi", 8'h00, 8'h00, 8'h00, 0, 3'd4);
    do_ack();     expect_st("R11 empty ack", 8'h00, 8'h00, 8'h00, 0, 3'd7);
    lines(8'h00);

    // R5 nesting, R6 end-of-service forms
    lines(8'h20); expect_st("R5 level 5 pending", 8'h20, 8'h00, 8'h00, 1, 3'd7);
    do_ack();     expect_st("R4 ack level 5", 8'h00, 8'h20, 8'h00, 0, 3'd5);
    lines(8'hA0); expect_st("R5 lower blocked", 8'h80, 8'h20, 8'h00, 0, 3'd5);
    lines(8'hA4); expect_st("R5 higher passes", 8'h84, 8'h20, 8'h00, 1, 3'd5);
    do_ack();     expect_st("R5 nested ack", 8'h80, 8'h24, 8'h00, 0, 3'd2);
    cmd(3'd1, 3'd0); expect_st("R6 general clears most urgent", 8'h80, 8'h20, 8'h00, 0, 3'd2);
    cmd(3'd2, 3'd5); expect_st("R6 specific clears 5", 8'h80, 8'h00, 8'h00, 1, 3'd2);
    do_ack();     expect_st("R4 ack level 7", 8'h00, 8'h80, 8'h00, 0, 3'd7);
    irq_lines = 8'h00; cmd(3'd1, 3'd0);
    expect_st("R6 clear 7", 8'h00, 8'h00, 8'h00, 0, 3'd7);

    // R9 mask
    set_mask(8'h08); expect_st("R9 mask write", 8'h00, 8'h00, 8'h08, 0, 3'd7);
    lines(8'h08);    expect_st("R9 masked request held, no irq", 8'h08, 8'h00, 8'h08, 0, 3'd7);
    set_mask(8'h00); expect_st("R9 unmask raises irq", 8'h08, 8'h00, 8'h00, 1, 3'd7);
    do_ack();        expect_st("R9 ack level 3", 8'h00, 8'h08, 8'h00, 0, 3'd3);
    irq_lines = 8'h00; cmd(3'd1, 3'd0);
    expect_st("R6 clear 3", 8'h00, 8'h00, 8'h00, 0, 3'd3);

    // R7 rotate on general end-of-service
    lines(8'h10); do_ack();
    expect_st("R7 ack level 4", 8'h00, 8'h10, 8'h00, 0, 3'd4);
    irq_lines = 8'h00; cmd(3'd3, 3'd0);
    expect_st("R7 rotating eoi", 8'h00, 8'h00, 8'h00, 0, 3'd4);
    lines(8'h41); expect_st("R7 two pending", 8'h41, 8'h00, 8'h00, 1, 3'd4);
    do_ack();     expect_st("R7 level 6 beats 0", 8'h01, 8'h40, 8'h00, 0, 3'd6);
    cmd(3'd2, 3'd6); expect_st("R7 clear 6", 8'h01, 8'h00, 8'h00, 1, 3'd6);
    do_ack();     expect_st("R7 then level 0", 8'h00, 8'h01, 8'h00, 0, 3'd0);
    irq_lines = 8'h00; cmd(3'd1, 3'd0);
    expect_st("R7 cleanup", 8'h00, 8'h00, 8'h00, 0, 3'd0);

    // R8 set bottom and rotating specific end-of-service
    cmd(3'd5, 3'd1);
    lines(8'h09); expect_st("R8 pending 0 and 3", 8'h09, 8'h00, 8'h00, 1, 3'd0);
    do_ack();     expect_st("R8 bottom 1 picks 3", 8'h01, 8'h08, 8'h00, 0, 3'd3);
    cmd(3'd4, 3'd3); expect_st("R8 rotating specific eoi", 8'h01, 8'h00, 8'h00, 1, 3'd3);
    do_ack();     expect_st("R8 ack level 0", 8'h00, 8'h01, 8'h00, 0, 3'd0);
    lines(8'h2D); expect_st("R8 5 more urgent than 0", 8'h24, 8'h01, 8'h00, 1, 3'd0);
    do_ack();     expect_st("R8 picks 5 under bottom 3", 8'h04, 8'h21, 8'h00, 0, 3'd5);
    cmd(3'd1, 3'd0); expect_st("R6 general clears 5 on ring", 8'h04, 8'h01, 8'h00, 0, 3'd5);
    cmd(3'd1, 3'd0); expect_st("R6 general clears 0", 8'h04, 8'h00, 8'h00, 1, 3'd5);
    do_ack();     expect_st("R8 ack level 2", 8'h00, 8'h04, 8'h00, 0, 3'd2);
    irq_lines = 8'h00; cmd(3'd1, 3'd0);
    expect_st("R8 cleanup", 8'h00, 8'h00, 8'h00, 0, 3'd2);
    cmd(3'd5, 3'd7);

    // R10 selective masking
    cmd(3'd6, 3'd0);
    lines(8'h10); do_ack();
    expect_st("R10 ack level 4", 8'h00, 8'h10, 8'h00, 0, 3'd4);
    set_mask(8'h10);
    lines(8'h50); expect_st("R10 lower level enabled", 8'h40, 8'h10, 8'h10, 1, 3'd4);
    do_ack();     expect_st("R10 ack level 6", 8'h00, 8'h50, 8'h10, 0, 3'd6);
    cmd(3'd1, 3'd0); expect_st("R10 general eoi skips masked 4", 8'h00, 8'h10, 8'h10, 0, 3'd6);
    cmd(3'd1, 3'd0); expect_st("R10 masked 4 stays", 8'h00, 8'h10, 8'h10, 0, 3'd6);
    irq_lines = 8'h00; cmd(3'd2, 3'd4);
    expect_st("R10 specific clears 4", 8'h00, 8'h00, 8'h10, 0, 3'd6);
    mask_we = 1; mask_data = 8'h00; cmd(3'd7, 3'd0);
    expect_st("R10 off", 8'h00, 8'h00, 8'h00, 0, 3'd6);
    lines(8'h10); do_ack();
    lines(8'h50); expect_st("R10 off restores blocking", 8'h40, 8'h10, 8'h00, 0, 3'd4);
    cmd(3'd1, 3'd0); do_ack();
    irq_lines = 8'h00; cmd(3'd1, 3'd0);
    expect_st("R10 cleanup", 8'h00, 8'h00, 8'h00, 0, 3'd6);

    // R3 level capture
    cfg_level_trig = 1; tick();
    lines(8'h02); expect_st("R3 level request", 8'h02, 8'h00, 8'h00, 1, 3'd6);
    lines(8'h00); expect_st("R3 not latched", 8'h00, 8'h00, 8'h00, 0, 3'd6);
    lines(8'h02); do_ack();
    expect_st("R3 ack level 1", 8'h00, 8'h02, 8'h00, 0, 3'd1);
    tick();       expect_st("R3 re-request blocked", 8'h02, 8'h02, 8'h00, 0, 3'd1);
    cmd(3'd1, 3'd0); expect_st("R3 re-request after eoi", 8'h02, 8'h00, 8'h00, 1, 3'd1);
    lines(8'h00); expect_st("R3 drops", 8'h00, 8'h00, 8'h00, 0, 3'd1);
    cfg_level_trig = 0; tick();

    // R12 automatic end-of-service
    cfg_auto_eoi = 1; tick();
    lines(8'h08); do_ack();
    expect_st("R12 ack level 3", 8'h00, 8'h08, 8'h00, 0, 3'd3);
    do_last();    expect_st("R12 auto clear", 8'h00, 8'h00, 8'h00, 0, 3'd3);
    cfg_auto_rotate = 1; lines(8'h00);
    lines(8'h02); do_ack();
    expect_st("R12 ack level 1", 8'h00, 8'h02, 8'h00, 0, 3'd1);
    do_last();    expect_st("R12 auto clear rotate", 8'h00, 8'h00, 8'h00, 0, 3'd1);
    lines(8'h05); expect_st("R12 pending 0 and 2", 8'h05, 8'h00, 8'h00, 1, 3'd1);
    do_ack();     expect_st("R12 rotated ring picks 2", 8'h01, 8'h04, 8'h00, 0, 3'd2);
    do_last();    expect_st("R12 auto clear 2", 8'h01, 8'h00, 8'h00, 1, 3'd2);

    tick(); tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule